// File: doc/BRIEF.md
# Banded dynamic-programming disparity tracer

This core finds the disparities of one rectified scanline pair by dynamic programming, without keeping the whole cost plane. It keeps a band of D accumulated path costs, one for each candidate disparity 0..D-1. Every accepted pixel advances the whole band by one step in parallel. Each state takes the cheapest of three moves: keep its disparity and pay that pixel's match cost, or come from a neighbouring disparity and pay a fixed occlusion cost. For every state and pixel, the move that won is written as a 2-bit tag into one of D small LIFO memories.

Once the line ends, the core walks the tags from the last pixel back to the first, starting at disparity 0. It emits one disparity per clock, in reverse pixel order. The match costs for all D candidates come from upstream, packed into one bus, one pixel per beat. A `line_start` pulse opens each line. Putting the output back into forward order is the consumer's job.

Top module: `dpb_stereo_core`

## Requirements
- R1: While reset is held and right after it, `busy` and `disp_valid` are 0.
- R2: Before the first pixel, state k holds min(k*occl_cost, MAX), where MAX = 2^CW-1. For each pixel, state k becomes the minimum of three terms: its own old cost plus `match_cost` slice k (bits k*CW+CW-1 : k*CW); old state k-1 plus occl_cost; old state k+1 plus occl_cost. A neighbour outside 0..D-1 counts as MAX.
- R3: On equal terms the own-disparity move wins first, then the move from k-1, then the move from k+1.
- R4: Backtracking starts at disparity 0 on the last pixel. Going one pixel back, the disparity is unchanged for an own-disparity move, drops by 1 for a move from k-1, and rises by 1 for a move from k+1. Consecutive outputs therefore differ by at most 1 and always stay below D.
- R5: `disp_valid` rises in the cycle after the last pixel is accepted. It stays high for exactly L consecutive cycles, where L is the line length. These cycles carry the disparities of pixels L-1 down to 0, and the first of them is 0.
- R6: `busy` is high from the cycle after an accepted `line_start` until the last disparity has been output. A `line_start` seen while `busy` is high has no effect.
- R7: `pix_valid` while idle is ignored: no output, `busy` stays 0.
- R8: A line ends on a pixel carrying `pix_last`, or on its N-th pixel even without `pix_last`.
- R9: All additions saturate at MAX and never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | Opens a line and loads the initial band (only when idle) |
| pix_valid | input | 1 | A pixel's match costs are present |
| pix_last | input | 1 | This pixel is the last of the line |
| match_cost | input | D*CW | Match cost per candidate disparity, slice k = disparity k |
| occl_cost | input | CW | Occlusion cost constant |
| busy | output | 1 | Line in progress (filling or tracing) |
| disp_valid | output | 1 | `disp` carries a disparity |
| disp | output | DW | Disparity, last pixel first |

## Verification
Two things can meet in one cycle: the output trace, and a request for a new line. The bench pulses `line_start` in the second trace cycle, and again in the final one, where the core is just returning to idle. It then checks that the disparity stream and the fall of `busy` match the reference model as if no pulse had been sent. Inside the band update, the three moves also meet in a single cycle whenever their costs tie. Small random costs, all-equal costs and saturating costs make such ties common, and every output beat is compared with a behavioural model that uses the same tie order.

// File: rtl/dpb_pkg.sv
package dpb_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_FILL, PH_TRACE} phase_e;
  localparam logic [1:0] TAG_KEEP = 2'b00;  // own disparity kept
  localparam logic [1:0] TAG_UP   = 2'b01;  // came from disparity k-1
  localparam logic [1:0] TAG_DOWN = 2'b11;  // came from disparity k+1
endpackage

// File: rtl/dpb_cell.sv
module dpb_cell
  import dpb_pkg::*;
#(
  parameter int CW = 10
) (
  input  logic [CW-1:0] own_q,
  input  logic [CW-1:0] lo_q,
  input  logic [CW-1:0] hi_q,
  input  logic [CW-1:0] mcost,
  input  logic [CW-1:0] occl,
  output logic [CW-1:0] cost_nx,
  output logic [1:0]    tag_nx
);
  localparam logic [CW-1:0] MAXV = '1;

  function automatic logic [CW-1:0] sat_add(input logic [CW-1:0] a, input logic [CW-1:0] b);
    logic [CW:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[CW] ? MAXV : s[CW-1:0];
  endfunction

  logic [CW-1:0] keep_c, up_c, down_c;

  always_comb begin
    keep_c = sat_add(own_q, mcost);
    up_c   = sat_add(lo_q, occl);
    down_c = sat_add(hi_q, occl);
    if (keep_c <= up_c && keep_c <= down_c) begin
      cost_nx = keep_c;
      tag_nx  = TAG_KEEP;
    end else if (up_c <= down_c) begin
      cost_nx = up_c;
      tag_nx  = TAG_UP;
    end else begin
      cost_nx = down_c;
      tag_nx  = TAG_DOWN;
    end
  end
endmodule

// File: rtl/dpb_tag_lifo.sv
module dpb_tag_lifo #(
  parameter int N  = 16,
  parameter int D  = 8,
  parameter int AW = 4,
  parameter int DW = 3
) (
  input  logic           clk,
  input  logic           we,
  input  logic [AW-1:0]  waddr,
  input  logic [2*D-1:0] wtags,
  input  logic [AW-1:0]  raddr,
  input  logic [DW-1:0]  rsel,
  output logic [1:0]     rtag
);
  logic [1:0] lane_rd [D];

  for (genvar g = 0; g < D; g++) begin : g_lane
    logic [1:0] mem [N];
    always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wtags[2*g +: 2];
    end
    assign lane_rd[g] = mem[raddr];
  end

  assign rtag = lane_rd[rsel];
endmodule

// File: rtl/dpb_tracer.sv
module dpb_tracer
  import dpb_pkg::*;
#(
  parameter int DW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  input  logic [1:0]    tag,
  output logic [DW-1:0] cur
);
  logic [DW-1:0] cur_d;

  always_comb begin
    cur_d = cur;
    if (clear) cur_d = '0;
    else if (step) begin
      unique case (tag)
        TAG_UP:   cur_d = cur - DW'(1);
        TAG_DOWN: cur_d = cur + DW'(1);
        default:  cur_d = cur;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= '0;
    else if (clear || step) cur <= cur_d;
  end
endmodule

// File: rtl/dpb_stereo_core.sv
module dpb_stereo_core
  import dpb_pkg::*;
#(
  parameter int N  = 16,
  parameter int D  = 8,
  parameter int CW = 10,
  localparam int DW = (D > 1) ? $clog2(D) : 1,
  localparam int AW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            line_start,
  input  logic            pix_valid,
  input  logic            pix_last,
  input  logic [D*CW-1:0] match_cost,
  input  logic [CW-1:0]   occl_cost,
  output logic            busy,
  output logic            disp_valid,
  output logic [DW-1:0]   disp
);
  localparam logic [CW-1:0] MAXV = '1;
  localparam int PW = CW + DW + 1;

  phase_e        ph_q, ph_d;
  logic [AW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] st_q   [D];
  logic [CW-1:0] st_nx  [D];
  logic [CW-1:0] init_c [D];
  logic [CW-1:0] lo_c   [D];
  logic [CW-1:0] hi_c   [D];
  logic [2*D-1:0] tag_bus;
  logic [1:0]    rd_tag;
  logic          start_acc, fill_acc, line_end, trace_en;

  assign start_acc = (ph_q == PH_IDLE) && line_start;
  assign fill_acc  = (ph_q == PH_FILL) && pix_valid;
  assign line_end  = fill_acc && (pix_last || cnt_q == AW'(N - 1));
  assign trace_en  = (ph_q == PH_TRACE);

  for (genvar k = 0; k < D; k++) begin : g_band
    logic [PW-1:0] prod;
    assign prod = PW'(occl_cost) * PW'(k);
    assign init_c[k] = (prod > PW'(MAXV)) ? MAXV : prod[CW-1:0];

    if (k == 0) begin : g_lo_edge
      assign lo_c[k] = MAXV;
    end else begin : g_lo_in
      assign lo_c[k] = st_q[k-1];
    end
    if (k == D - 1) begin : g_hi_edge
      assign hi_c[k] = MAXV;
    end else begin : g_hi_in
      assign hi_c[k] = st_q[k+1];
    end

    dpb_cell #(.CW(CW)) u_cell (
      .own_q   (st_q[k]),
      .lo_q    (lo_c[k]),
      .hi_q    (hi_c[k]),
      .mcost   (match_cost[k*CW +: CW]),
      .occl    (occl_cost),
      .cost_nx (st_nx[k]),
      .tag_nx  (tag_bus[2*k +: 2])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q[k] <= '0;
      else if (start_acc) st_q[k] <= init_c[k];
      else if (fill_acc) st_q[k] <= st_nx[k];
    end
  end

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    unique case (ph_q)
      PH_IDLE: if (line_start) begin
        ph_d  = PH_FILL;
        cnt_d = '0;
      end
      PH_FILL: if (pix_valid) begin
        if (line_end) ph_d = PH_TRACE;
        else cnt_d = cnt_q + AW'(1);
      end
      PH_TRACE: begin
        if (cnt_q == '0) ph_d = PH_IDLE;
        else cnt_d = cnt_q - AW'(1);
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  dpb_tag_lifo #(.N(N), .D(D), .AW(AW), .DW(DW)) u_tags (
    .clk   (clk),
    .we    (fill_acc),
    .waddr (cnt_q),
    .wtags (tag_bus),
    .raddr (cnt_q),
    .rsel  (disp),
    .rtag  (rd_tag)
  );

  dpb_tracer #(.DW(DW)) u_trace (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (line_end),
    .step  (trace_en),
    .tag   (rd_tag),
    .cur   (disp)
  );

  assign busy       = (ph_q != PH_IDLE);
  assign disp_valid = trace_en;
endmodule

// File: rtl/dpb_stereo_core_chk.sv
module dpb_stereo_core_chk #(
  parameter int D  = 8,
  parameter int DW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          line_start,
  input logic          busy,
  input logic          disp_valid,
  input logic [DW-1:0] disp
);
  assert_valid_inside_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> busy);

  assert_disp_in_band_R4: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (int'(disp) < D));

  assert_unit_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && $past(disp_valid)) |->
      ((int'(disp) - int'($past(disp)) <= 1) && (int'($past(disp)) - int'(disp) <= 1)));

  assert_first_is_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disp_valid) |-> (disp == '0));

  assert_busy_ends_on_output_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(disp_valid));

  assert_start_from_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && line_start) |=> (busy && !disp_valid));
endmodule

bind dpb_stereo_core dpb_stereo_core_chk #(.D(D), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .line_start (line_start),
  .busy       (busy),
  .disp_valid (disp_valid),
  .disp       (disp)
);

// File: tb/test_dpb_stereo_core.sv
module test_dpb_stereo_core;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 16;
  localparam int D  = 8;
  localparam int CW = 10;
  localparam int DW = 3;
  localparam int MAXC = (1 << CW) - 1;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            line_start, pix_valid, pix_last;
  logic [D*CW-1:0] match_cost;
  logic [CW-1:0]   occl_cost;
  logic            busy, disp_valid;
  logic [DW-1:0]   disp;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  int mcost [N][D];
  int expd  [N];

  dpb_stereo_core #(.N(N), .D(D), .CW(CW)) i_dpb_stereo_core (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .pix_valid(pix_valid),
    .pix_last(pix_last), .match_cost(match_cost), .occl_cost(occl_cost),
    .busy(busy), .disp_valid(disp_valid), .disp(disp)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat(input int a, input int b);
    return (a + b > MAXC) ? MAXC : a + b;
  endfunction

  // Behavioural model: full recursion with integers, then walk back (R2, R3, R4, R9)
  function automatic void ref_model(input int len, input int oc);
    int prev [D];
    int nxt  [D];
    int tg   [N][D];
    int d;
    for (int k = 0; k < D; k++) prev[k] = (k * oc > MAXC) ? MAXC : k * oc;
    for (int i = 0; i < len; i++) begin
      for (int k = 0; k < D; k++) begin
        int a, b, c;
        a = sat(prev[k], mcost[i][k]);
        b = (k > 0) ? sat(prev[k-1], oc) : MAXC;
        c = (k < D - 1) ? sat(prev[k+1], oc) : MAXC;
        if (a <= b && a <= c) begin nxt[k] = a; tg[i][k] = 0; end
        else if (b <= c) begin nxt[k] = b; tg[i][k] = 1; end
        else begin nxt[k] = c; tg[i][k] = -1; end
      end
      for (int k = 0; k < D; k++) prev[k] = nxt[k];
    end
    d = 0;
    for (int i = len - 1; i >= 0; i--) begin
      expd[i] = d;
      d = d - tg[i][d];
    end
  endfunction

  task automatic run_line(input int len, input int oc, input bit use_last,
                          input bit poke, input string req);
    ref_model(len, oc);
    @(negedge clk);
    occl_cost  = CW'(oc);
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    chk(busy == 1'b1, "R6 busy after start", int'(busy), 1);
    for (int i = 0; i < len; i++) begin
      chk(disp_valid == 1'b0, "R5 no output while filling", int'(disp_valid), 0);
      pix_valid = 1'b1;
      pix_last  = use_last && (i == len - 1);
      for (int k = 0; k < D; k++) match_cost[k*CW +: CW] = CW'(mcost[i][k]);
      if (poke && i == 2) line_start = 1'b1;
      @(negedge clk);
      line_start = 1'b0;
    end
    pix_valid = 1'b0;
    pix_last  = 1'b0;
    for (int c = 0; c < len; c++) begin
      chk(disp_valid == 1'b1, {req, " valid during trace (R5)"}, int'(disp_valid), 1);
      chk(int'(disp) == expd[len-1-c], {req, " disparity (R4)"}, int'(disp), expd[len-1-c]);
      chk(busy == 1'b1, "R6 busy during trace", int'(busy), 1);
      line_start = poke && (c == 1 || c == len - 1);
      @(negedge clk);
    end
    line_start = 1'b0;
    chk(disp_valid == 1'b0, {req, " trace length (R5)"}, int'(disp_valid), 0);
    chk(busy == 1'b0, {req, " idle after trace (R6)"}, int'(busy), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; line_start = 1'b0; pix_valid = 1'b0; pix_last = 1'b0;
    match_cost = '0; occl_cost = '0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
    chk(disp_valid == 1'b0, "R1 valid in reset", int'(disp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);

    // R7: pixels while idle are ignored
    for (int j = 0; j < 4; j++) begin
      pix_valid = 1'b1; pix_last = (j == 3);
      @(negedge clk);
      chk(busy == 1'b0, "R7 idle pixel busy", int'(busy), 0);
      chk(disp_valid == 1'b0, "R7 idle pixel output", int'(disp_valid), 0);
    end
    pix_valid = 1'b0; pix_last = 1'b0;

    // R3: all costs zero -> every tie keeps disparity, all outputs 0
    for (int i = 0; i < N; i++) for (int k = 0; k < D; k++) mcost[i][k] = 0;
    run_line(N, 0, 1'b1, 1'b0, "R3 all-tie");

    // R3: equal match costs, zero occlusion -> neighbour ties
    for (int i = 0; i < N; i++) for (int k = 0; k < D; k++) mcost[i][k] = 5;
    run_line(N, 0, 1'b1, 1'b0, "R3 neighbour-tie");

    // R2/R4: staircase of true disparities
    for (int i = 0; i < N; i++)
      for (int k = 0; k < D; k++) mcost[i][k] = (k == (i / 2) % D) ? 0 : 60;
    run_line(N, 10, 1'b1, 1'b0, "R2 staircase");

    // R2: random small costs, many ties
    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < N; i++) for (int k = 0; k < D; k++) mcost[i][k] = int'($urandom_range(0, 3));
      run_line(N, int'($urandom_range(0, 2)), 1'b1, 1'b0, "R2 random-small");
    end

    // R9: costs near full scale saturate
    for (int i = 0; i < N; i++) for (int k = 0; k < D; k++) mcost[i][k] = 900 + int'($urandom_range(0, 123));
    run_line(N, 700, 1'b1, 1'b0, "R9 saturation");

    // R5: short line ended by pix_last
    for (int i = 0; i < N; i++) for (int k = 0; k < D; k++) mcost[i][k] = int'($urandom_range(0, 40));
    run_line(5, 7, 1'b1, 1'b0, "R5 short");
    run_line(1, 3, 1'b1, 1'b0, "R5 single");

    // R8: no pix_last, line closes at N pixels
    for (int i = 0; i < N; i++) for (int k = 0; k < D; k++) mcost[i][k] = int'($urandom_range(0, 30));
    run_line(N, 4, 1'b0, 1'b0, "R8 forced end");

    // R6: start pulses while busy ignored
    for (int i = 0; i < N; i++) for (int k = 0; k < D; k++) mcost[i][k] = int'($urandom_range(0, 20));
    run_line(9, 5, 1'b1, 1'b1, "R6 start while busy");
    run_line(N, 5, 1'b1, 1'b1, "R6 start while busy full");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule